// File: doc/BRIEF.md
# Serial Programming Mode Entry Interface

This block is the target-side front end of an in-circuit serial programming port on a small microcontroller. It watches a digitised high-voltage-detect flag from the reset pin, a supply-good flag, and the programming clock and data pins. From the order in which these change, it decides whether the device goes into programming/verify mode.

While the mode is active the block holds the rest of the chip in reset and forces every general-purpose I/O to a high-impedance input by masking the core's output enables. On entry it pulses a clear to the program address counter. It then assembles serial words from the data pin, least significant bit first, sampling on each falling edge of the programming clock. Each completed word is presented with a one-cycle strobe. A width input chooses between a short command word and a long data word. Command decode, the memory array and analog detection sit outside this block.

Top module: `sp_entry_port`

## Requirements
- R1: After reset, `prog_mode_o`, `core_rst_o`, `addr_clr_o` and `word_valid_o` are 0, and `io_oe_o` equals `io_oe_i`.
- R2: With `pwr_good_i` already high, a rising `hv_det_i` while both programming pins are low sets `prog_mode_o` at the next clock edge.
- R3: A rising `hv_det_i` while `pwr_good_i` is low and both pins are low arms entry without entering. `prog_mode_o` is set at the clock edge after `pwr_good_i` later rises, provided `hv_det_i` is still high.
- R4: If either programming pin is high when `hv_det_i` rises, entry is refused. Entry stays refused, even after the pins go low, until `hv_det_i` falls and rises again. A rising `hv_det_i` present at reset release does not count as a rise.
- R5: While `prog_mode_o` is 1, `core_rst_o` is 1 and every bit of `io_oe_o` is 0.
- R6: `addr_clr_o` is a single-cycle pulse in the first cycle of each entry, and it is 0 at all other times.
- R7: A low `hv_det_i` or a low `pwr_good_i` during the mode clears `prog_mode_o` at the next edge. `core_rst_o` is then released and `io_oe_o` follows `io_oe_i` again.
- R8: Bits are sampled from the data pin on falling edges of the programming clock. The first falling edge after entry supplies bit 0, which is the least significant bit.
- R9: With `wide_i` = 0, a word is `CMD_W` (6) bits long and `word_o` bits above `CMD_W-1` are 0. With `wide_i` = 1, a word is `DATA_W` (14) bits long.
- R10: `word_valid_o` is high for exactly one cycle. It rises at the third system clock edge after the pin falling edge that carries the last bit, with `word_o` holding the word.
- R11: Leaving the mode discards any partial word, so after re-entry the next falling edge again supplies bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hv_det_i | input | 1 | High voltage detected on the reset pin |
| pwr_good_i | input | 1 | Supply is within operating range |
| pclk_i | input | 1 | Programming clock pin (asynchronous) |
| pdat_i | input | 1 | Programming data pin (asynchronous) |
| wide_i | input | 1 | 0: command word length, 1: data word length |
| io_oe_i | input | NUM_IO | Output enables requested by the core |
| io_oe_o | output | NUM_IO | Output enables delivered to the pads |
| prog_mode_o | output | 1 | Programming/verify mode active |
| core_rst_o | output | 1 | Holds the remaining device logic in reset |
| addr_clr_o | output | 1 | One-cycle clear for the address counter |
| word_valid_o | output | 1 | One-cycle strobe: word_o holds a new word |
| word_o | output | DATA_W | Assembled word, bit 0 received first |

## Verification
The mode outputs `prog_mode_o`, `core_rst_o`, `io_oe_o` and `addr_clr_o` change one clock edge after the `hv_det_i` or `pwr_good_i` change that causes them. The bench therefore drives those inputs at a falling system clock edge and checks the outputs at the next falling edge. A received word is due three edges after the pin falling edge of its last bit: two edges go through the synchroniser and one through the output register. The driver stamps each expected word with that due cycle. The monitor checks both the value and the exact cycle of every `word_valid_o`, and it also flags any strobe that no word was expected for.

// File: rtl/sp_entry_pkg.sv
package sp_entry_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ARMED  = 2'd1,
      ST_LOCKED = 2'd2,
      ST_ACTIVE = 2'd3
   } entry_state_e;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sp_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain_q[STAGES-1];
   end
endmodule

// File: rtl/sp_entry_fsm.sv
module sp_entry_fsm
   import sp_entry_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hv_i,
   input  logic pg_i,
   input  logic pins_low_i,
   output logic mode_o,
   output logic addr_clr_o
);
   entry_state_e state_q, state_d;
   logic         hv_prev_q;
   logic         hv_rise;

   // hv_prev resets high: a level already present at reset is not a rise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hv_prev_q <= 1'b1;
      else        hv_prev_q <= hv_i;
   end
   assign hv_rise = hv_i & ~hv_prev_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (hv_rise) begin
               if (!pins_low_i)  state_d = ST_LOCKED;
               else if (pg_i)    state_d = ST_ACTIVE;
               else              state_d = ST_ARMED;
            end
         end
         ST_ARMED: begin
            if (!hv_i)           state_d = ST_IDLE;
            else if (pg_i)       state_d = pins_low_i ? ST_ACTIVE : ST_LOCKED;
         end
         ST_LOCKED: begin
            if (!hv_i)           state_d = ST_IDLE;
         end
         ST_ACTIVE: begin
            if (!hv_i || !pg_i)  state_d = ST_IDLE;
         end
         default:                state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         addr_clr_o <= 1'b0;
      end else begin
         state_q    <= state_d;
         addr_clr_o <= (state_d == ST_ACTIVE) && (state_q != ST_ACTIVE);
      end
   end

   assign mode_o = (state_q == ST_ACTIVE);
endmodule

// File: rtl/sp_shift_rx.sv
module sp_shift_rx #(
   parameter int CMD_W  = 6,
   parameter int DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              wide_i,
   input  logic              sclk_i,
   input  logic              sdat_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] word_o
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

   logic              sclk_prev_q;
   logic              fall;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  last_idx;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] acc_next;

   assign fall     = sclk_prev_q & ~sclk_i;
   assign last_idx = wide_i ? LAST_DATA : LAST_CMD;
   assign acc_next = acc_q | ({{(DATA_W-1){1'b0}}, sdat_i} << cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev_q <= 1'b0;
         cnt_q       <= '0;
         acc_q       <= '0;
         valid_o     <= 1'b0;
         word_o      <= '0;
      end else begin
         sclk_prev_q <= sclk_i;
         valid_o     <= 1'b0;
         if (!active_i) begin
            cnt_q <= '0;
            acc_q <= '0;
         end else if (fall) begin
            if (cnt_q >= last_idx) begin
               word_o  <= acc_next;
               valid_o <= 1'b1;
               cnt_q   <= '0;
               acc_q   <= '0;
            end else begin
               acc_q <= acc_next;
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sp_entry_port.sv
module sp_entry_port #(
   parameter int NUM_IO      = 8,
   parameter int CMD_W       = 6,
   parameter int DATA_W      = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hv_det_i,
   input  logic              pwr_good_i,
   input  logic              pclk_i,
   input  logic              pdat_i,
   input  logic              wide_i,
   input  logic [NUM_IO-1:0] io_oe_i,
   output logic [NUM_IO-1:0] io_oe_o,
   output logic              prog_mode_o,
   output logic              core_rst_o,
   output logic              addr_clr_o,
   output logic              word_valid_o,
   output logic [DATA_W-1:0] word_o
);
   if (CMD_W < 1 || CMD_W >= DATA_W) begin : g_bad_width
      $error("sp_entry_port: need 1 <= CMD_W < DATA_W");
   end
   if (NUM_IO < 1) begin : g_bad_io
      $error("sp_entry_port: NUM_IO must be positive");
   end

   logic [1:0] pins_sync;
   logic       mode;

   sp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({pdat_i, pclk_i}),
      .q_o   (pins_sync)
   );

   sp_entry_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .hv_i       (hv_det_i),
      .pg_i       (pwr_good_i),
      .pins_low_i (pins_sync == 2'b00),
      .mode_o     (mode),
      .addr_clr_o (addr_clr_o)
   );

   sp_shift_rx #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (mode),
      .wide_i   (wide_i),
      .sclk_i   (pins_sync[0]),
      .sdat_i   (pins_sync[1]),
      .valid_o  (word_valid_o),
      .word_o   (word_o)
   );

   for (genvar i = 0; i < NUM_IO; i++) begin : g_pad
      assign io_oe_o[i] = io_oe_i[i] & ~mode;
   end

   assign prog_mode_o = mode;
   assign core_rst_o  = mode;
endmodule

// File: rtl/sp_entry_port_chk.sv
module sp_entry_port_chk #(
   parameter int NUM_IO = 8,
   parameter int DATA_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hv_det_i,
   input logic              pwr_good_i,
   input logic [NUM_IO-1:0] io_oe_o,
   input logic              prog_mode_o,
   input logic              core_rst_o,
   input logic              addr_clr_o,
   input logic              word_valid_o
);
   p_reset_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      prog_mode_o |-> core_rst_o);
   p_pads_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
      prog_mode_o |-> (io_oe_o == '0));
   p_clr_on_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_mode_o) |-> addr_clr_o);
   p_clr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      addr_clr_o |=> !addr_clr_o);
   p_clr_only_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      addr_clr_o |-> prog_mode_o);
   p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_mode_o && (!hv_det_i || !pwr_good_i)) |=> !prog_mode_o);
   p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |=> !word_valid_o);
   p_strobe_in_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> $past(prog_mode_o));
endmodule

bind sp_entry_port sp_entry_port_chk #(.NUM_IO(NUM_IO), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hv_det_i     (hv_det_i),
   .pwr_good_i   (pwr_good_i),
   .io_oe_o      (io_oe_o),
   .prog_mode_o  (prog_mode_o),
   .core_rst_o   (core_rst_o),
   .addr_clr_o   (addr_clr_o),
   .word_valid_o (word_valid_o)
);

// File: tb/sp_entry_port_tb_top.sv
module sp_entry_port_tb_top;
   localparam int NUM_IO = 8;
   localparam int DATA_W = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hv = 1'b0, pg = 1'b0, pclk = 1'b0, pdat = 1'b0, wide = 1'b0;
   logic [NUM_IO-1:0] oe_in = 8'hA5;
   logic [NUM_IO-1:0] oe_out;
   logic mode, crst, aclr, wvalid;
   logic [DATA_W-1:0] word;

   int errors = 0;
   int checks = 0;
   int unsigned cyc = 0;
   bit done = 0;

   typedef struct packed {
      logic [DATA_W-1:0] w;
      logic [31:0]       due;
   } exp_t;
   exp_t sb_q[$];

   always #10 clk = ~clk;  // 50 MHz

   always @(posedge clk) cyc <= cyc + 1;

   sp_entry_port dut_i (
      .clk(clk), .rst_n(rst_n), .hv_det_i(hv), .pwr_good_i(pg),
      .pclk_i(pclk), .pdat_i(pdat), .wide_i(wide),
      .io_oe_i(oe_in), .io_oe_o(oe_out), .prog_mode_o(mode),
      .core_rst_o(crst), .addr_clr_o(aclr), .word_valid_o(wvalid),
      .word_o(word)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver: shifts nbits of val LSB first, queues the expected word
   task automatic send_word(input logic [DATA_W-1:0] val, input int nbits, input bit expect_word);
      for (int b = 0; b < nbits; b++) begin
         pclk = 1'b1;
         cycles(2);
         pdat = val[b];
         cycles(3);
         pclk = 1'b0;
         if (b == nbits - 1 && expect_word) begin
            exp_t e;
            e.w   = val;
            e.due = cyc + 3;
            sb_q.push_back(e);
         end
         cycles(4);
      end
      pdat = 1'b0;
   endtask

   // monitor: R8 R9 R10 value and cycle of every strobe
   always @(negedge clk) begin
      if (rst_n && wvalid) begin
         if (sb_q.size() == 0) begin
            check("R10 unexpected word_valid", 32'(word), 32'hFFFF_FFFF);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check("R8/R9 word value", 32'(word), 32'(e.w));
            check("R10 strobe cycle", cyc, e.due);
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 20000 && !done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<20000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(2);
      // R1 reset state
      check("R1 prog_mode", 32'(mode), 0);
      check("R1 core_rst", 32'(crst), 0);
      check("R1 addr_clr", 32'(aclr), 0);
      check("R1 word_valid", 32'(wvalid), 0);
      check("R1 io_oe pass", 32'(oe_out), 32'(oe_in));

      // R2 supply first, then high voltage
      pg = 1'b1;
      cycles(3);
      hv = 1'b1;
      cycles(1);
      check("R2 entry", 32'(mode), 1);
      check("R6 clear pulse", 32'(aclr), 1);
      cycles(1);
      check("R6 clear ends", 32'(aclr), 0);
      check("R5 core reset", 32'(crst), 1);
      check("R5 pads floated", 32'(oe_out), 0);

      // R8 R9 command then data word
      wide = 1'b0;
      send_word(14'h002D, 6, 1);
      wide = 1'b1;
      send_word(14'h2A5C, 14, 1);
      send_word(14'h1001, 14, 1);
      cycles(5);

      // R11 partial word then exit by high voltage drop
      wide = 1'b0;
      send_word(14'h003F, 3, 0);
      hv = 1'b0;
      cycles(1);
      check("R7 exit on hv low", 32'(mode), 0);
      check("R7 reset released", 32'(crst), 0);
      check("R7 pads restored", 32'(oe_out), 32'(oe_in));
      cycles(2);
      hv = 1'b1;
      cycles(1);
      check("R11 re-entry", 32'(mode), 1);
      send_word(14'h0013, 6, 1);  // R11 restarts at bit 0
      cycles(5);

      // R7 supply loss
      pg = 1'b0;
      cycles(1);
      check("R7 exit on supply loss", 32'(mode), 0);

      // R3 high voltage first, then supply
      hv = 1'b0;
      cycles(2);
      hv = 1'b1;
      cycles(4);
      check("R3 armed not entered", 32'(mode), 0);
      pg = 1'b1;
      cycles(1);
      check("R3 entry on supply", 32'(mode), 1);
      check("R3 clear pulse", 32'(aclr), 1);
      wide = 1'b1;
      send_word(14'h3FFE, 14, 1);
      cycles(5);

      // R4 refusal with clock pin high
      hv = 1'b0;
      pclk = 1'b1;
      cycles(4);
      hv = 1'b1;
      cycles(4);
      check("R4 refused", 32'(mode), 0);
      pclk = 1'b0;
      cycles(4);
      check("R4 still locked", 32'(mode), 0);
      check("R4 pads untouched", 32'(oe_out), 32'(oe_in));
      hv = 1'b0;
      cycles(2);
      hv = 1'b1;
      cycles(1);
      check("R4 entry after new rise", 32'(mode), 1);
      cycles(10);

      check("R10 all words seen", sb_q.size(), 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule